// File: doc/BRIEF.md
# Register Rename Table with Result Snooping

This block keeps, for every architectural register of a small register file, either its current value or the identity of the in-flight operation that will produce it. Each entry stores a value, a valid flag and the tag of the most recent producer assigned to that register. A rename front end drives two source register indices and one destination index per cycle. It gets back, for each source, either a ready value or the tag to wait on. When a rename is accepted, it also gets the fresh tag for its destination.

Finished results come back on a broadcast bus carrying a tag and a value. Every waiting entry compares its stored producer tag with the bus. Only the entry still expecting that exact producer captures the value. An entry that was renamed again since then keeps waiting for its newer producer. The block also owns the pool of producer tags. It hands out the lowest-numbered free tag on each accepted rename. A tag goes back to the pool when its result is broadcast. Renaming is held off whenever the downstream scheduling buffer reports no room or no tag is left.

Top module: `rat_rename_table`

## Requirements
- R1: After reset every register reads as ready with value 0, and all TAGS tags are free, so TAGS renames in a row are accepted with tags 0, 1, 2 and so on.
- R2: A source read of a valid register returns src_*_ready = 1 and the stored value in the same cycle.
- R3: A source read of a pending register, with no matching broadcast that cycle, returns src_*_ready = 0 and the pending producer tag on src_*_tag.
- R4: A rename is accepted (ren_fire = 1) exactly when ren_valid = 1, rs_avail = 1 and at least one tag is free. ren_tag is then the lowest-numbered free tag. From the next cycle the destination register is pending on that tag.
- R5: A broadcast whose tag equals the stored tag of a pending register makes that register valid, holding the broadcast value, from the next cycle.
- R6: A broadcast is ignored by every register that is valid or whose stored tag differs from the broadcast tag, even a register that earlier waited on that producer.
- R7: A source read of a pending register in a cycle where the broadcast tag matches its stored tag returns ready with the broadcast value.
- R8: When a source index equals the destination index of an accepted rename, the source sees the register as it was before the rename.
- R9: With rs_avail = 0 no rename is accepted, no tag is consumed and no register changes.
- R10: A tag returns to the free pool in the cycle after its result is broadcast and can then be allocated again. While all tags are in flight, ren_fire stays 0.
- R11: When an accepted rename and a matching broadcast hit the same register in one cycle, the rename wins: the register is left pending on the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request this cycle |
| rs_avail | input | 1 | Scheduling buffer has a free slot |
| ren_dst | input | AREG_W | Destination register index |
| src_a_idx | input | AREG_W | First source register index |
| src_b_idx | input | AREG_W | Second source register index |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| ren_fire | output | 1 | Rename accepted this cycle |
| ren_tag | output | TAG_W | Tag given to the destination |
| src_a_ready | output | 1 | First source value available |
| src_a_value | output | DATA_W | First source value |
| src_a_tag | output | TAG_W | First source producer tag when not ready |
| src_b_ready | output | 1 | Second source value available |
| src_b_value | output | DATA_W | Second source value |
| src_b_tag | output | TAG_W | Second source producer tag when not ready |

## Verification
Several properties hold on every cycle, and the bound checker enforces them: an accepted rename leaves its register pending on the issued tag, and a matching broadcast wakes a pending register. A register that neither a rename nor a matching broadcast touches holds still. The checker also requires that no rename fires without buffer room or a free tag, and that bypassed reads show the bus value. Some behaviour shows only in the bench's scenarios, where a reference model of the table and tag pool predicts every cycle's outputs. This covers the lowest-free allocation order and the reuse of a tag after it is broadcast. It also covers a stale broadcast reaching a re-renamed register, a reused tag reaching a register that is already valid, and tag exhaustion.

// File: rtl/rat_pkg.sv
package rat_pkg;

    // Default geometry of the rename table
    localparam int RAT_REGS   = 8;
    localparam int RAT_DATA_W = 16;
    localparam int RAT_TAGS   = 8;

    // Where a source read obtained its answer
    typedef enum logic [1:0] {
        SRC_TABLE  = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_WAIT   = 2'd2
    } src_kind_e;

    // A pending entry captures a broadcast only if it still expects that tag
    function automatic logic snoop_hit(input logic bus_valid,
                                       input logic ent_ready,
                                       input logic tag_equal);
        return bus_valid && !ent_ready && tag_equal;
    endfunction

endpackage

// File: rtl/rat_tag_pool.sv
module rat_tag_pool
    import rat_pkg::*;
#(
    parameter int TAGS  = RAT_TAGS,
    parameter int TAG_W = $clog2(TAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             give_valid,
    input  logic [TAG_W-1:0] give_tag,
    output logic             has_free,
    output logic [TAG_W-1:0] grant_tag,
    output logic [TAGS-1:0]  free_mask
);

    logic [TAGS-1:0] free_nxt;

    // Lowest-numbered free tag: scan downward so the lowest set bit wins
    always_comb begin
        grant_tag = '0;
        for (int i = TAGS - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                grant_tag = TAG_W'(i);
            end
        end
    end

    assign has_free = |free_mask;

    always_comb begin
        free_nxt = free_mask;
        if (take) begin
            free_nxt[grant_tag] = 1'b0;
        end
        if (give_valid) begin
            free_nxt[give_tag] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_mask <= '1;
        end else begin
            free_mask <= free_nxt;
        end
    end

endmodule

// File: rtl/rat_entry.sv
module rat_entry
    import rat_pkg::*;
#(
    parameter int DATA_W = RAT_DATA_W,
    parameter int TAG_W  = $clog2(RAT_TAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren_hit,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_value,
    output logic [TAG_W-1:0]  q_tag
);

    logic wake;

    assign wake = snoop_hit(bc_valid, q_valid, bc_tag == q_tag);

    // Rename has priority over a same-cycle wakeup of the old producer
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b1;
            q_value <= '0;
            q_tag   <= '0;
        end else if (ren_hit) begin
            q_valid <= 1'b0;
            q_tag   <= new_tag;
        end else if (wake) begin
            q_valid <= 1'b1;
            q_value <= bc_value;
        end
    end

endmodule

// File: rtl/rat_src_port.sv
module rat_src_port
    import rat_pkg::*;
#(
    parameter int DATA_W = RAT_DATA_W,
    parameter int TAG_W  = $clog2(RAT_TAGS)
) (
    input  logic              ent_valid,
    input  logic [DATA_W-1:0] ent_value,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_value,
    output logic [TAG_W-1:0]  rd_tag
);

    src_kind_e kind;

    always_comb begin
        if (ent_valid) begin
            kind = SRC_TABLE;
        end else if (snoop_hit(bc_valid, ent_valid, bc_tag == ent_tag)) begin
            kind = SRC_BYPASS;
        end else begin
            kind = SRC_WAIT;
        end
    end

    always_comb begin
        rd_tag = ent_tag;
        unique case (kind)
            SRC_TABLE: begin
                rd_ready = 1'b1;
                rd_value = ent_value;
            end
            SRC_BYPASS: begin
                rd_ready = 1'b1;
                rd_value = bc_value;
            end
            default: begin
                rd_ready = 1'b0;
                rd_value = ent_value;
            end
        endcase
    end

endmodule

// File: rtl/rat_rename_table.sv
module rat_rename_table
    import rat_pkg::*;
#(
    parameter int REGS   = RAT_REGS,
    parameter int DATA_W = RAT_DATA_W,
    parameter int TAGS   = RAT_TAGS,
    localparam int AREG_W = $clog2(REGS),
    localparam int TAG_W  = $clog2(TAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren_valid,
    input  logic              rs_avail,
    input  logic [AREG_W-1:0] ren_dst,
    input  logic [AREG_W-1:0] src_a_idx,
    input  logic [AREG_W-1:0] src_b_idx,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              ren_fire,
    output logic [TAG_W-1:0]  ren_tag,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag
);

    localparam int NUM_SRC = 2;

    logic              ent_valid [REGS];
    logic [DATA_W-1:0] ent_value [REGS];
    logic [TAG_W-1:0]  ent_tag   [REGS];

    logic              has_free;
    logic [TAG_W-1:0]  grant_tag;
    logic [TAGS-1:0]   free_mask;

    logic [AREG_W-1:0] rd_idx   [NUM_SRC];
    logic              rd_ready [NUM_SRC];
    logic [DATA_W-1:0] rd_value [NUM_SRC];
    logic [TAG_W-1:0]  rd_tag   [NUM_SRC];

    assign ren_fire = ren_valid && rs_avail && has_free;
    assign ren_tag  = grant_tag;

    rat_tag_pool #(
        .TAGS (TAGS),
        .TAG_W(TAG_W)
    ) u_pool (
        .clk       (clk),
        .rst       (rst),
        .take      (ren_fire),
        .give_valid(bc_valid),
        .give_tag  (bc_tag),
        .has_free  (has_free),
        .grant_tag (grant_tag),
        .free_mask (free_mask)
    );

    for (genvar r = 0; r < REGS; r++) begin : g_ent
        logic hit;
        assign hit = ren_fire && (ren_dst == AREG_W'(r));
        rat_entry #(
            .DATA_W(DATA_W),
            .TAG_W (TAG_W)
        ) u_ent (
            .clk     (clk),
            .rst     (rst),
            .ren_hit (hit),
            .new_tag (grant_tag),
            .bc_valid(bc_valid),
            .bc_tag  (bc_tag),
            .bc_value(bc_value),
            .q_valid (ent_valid[r]),
            .q_value (ent_value[r]),
            .q_tag   (ent_tag[r])
        );
    end

    assign rd_idx[0] = src_a_idx;
    assign rd_idx[1] = src_b_idx;

    // Reads use the table state before this cycle's rename lands
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rat_src_port #(
            .DATA_W(DATA_W),
            .TAG_W (TAG_W)
        ) u_port (
            .ent_valid(ent_valid[rd_idx[s]]),
            .ent_value(ent_value[rd_idx[s]]),
            .ent_tag  (ent_tag[rd_idx[s]]),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_value (bc_value),
            .rd_ready (rd_ready[s]),
            .rd_value (rd_value[s]),
            .rd_tag   (rd_tag[s])
        );
    end

    assign src_a_ready = rd_ready[0];
    assign src_a_value = rd_value[0];
    assign src_a_tag   = rd_tag[0];
    assign src_b_ready = rd_ready[1];
    assign src_b_value = rd_value[1];
    assign src_b_tag   = rd_tag[1];

endmodule

// File: rtl/rat_rename_table_chk.sv
module rat_rename_table_chk #(
    parameter int REGS   = 8,
    parameter int DATA_W = 16,
    parameter int TAGS   = 8,
    localparam int AREG_W = $clog2(REGS),
    localparam int TAG_W  = $clog2(TAGS)
) (
    input logic              clk,
    input logic              rst,
    input logic              rs_avail,
    input logic [AREG_W-1:0] ren_dst,
    input logic [AREG_W-1:0] src_a_idx,
    input logic              bc_valid,
    input logic [TAG_W-1:0]  bc_tag,
    input logic [DATA_W-1:0] bc_value,
    input logic              ren_fire,
    input logic [TAG_W-1:0]  ren_tag,
    input logic              src_a_ready,
    input logic [DATA_W-1:0] src_a_value,
    input logic [TAG_W-1:0]  src_a_tag,
    input logic              ent_valid [REGS],
    input logic [DATA_W-1:0] ent_value [REGS],
    input logic [TAG_W-1:0]  ent_tag   [REGS],
    input logic [TAGS-1:0]   free_mask
);

    // R9
    stall_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
        !rs_avail |-> !ren_fire);

    // R10
    alloc_from_free_chk: assert property (@(posedge clk) disable iff (rst)
        ren_fire |-> free_mask[ren_tag]);

    // R10
    empty_pool_chk: assert property (@(posedge clk) disable iff (rst)
        (free_mask == '0) |-> !ren_fire);

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && !ent_valid[src_a_idx] && ent_tag[src_a_idx] == bc_tag)
        |-> (src_a_ready && src_a_value == bc_value));

    // R3
    pending_tag_chk: assert property (@(posedge clk) disable iff (rst)
        !src_a_ready |-> (!ent_valid[src_a_idx] && src_a_tag == ent_tag[src_a_idx]));

    for (genvar g = 0; g < REGS; g++) begin : g_reg
        // R4
        rename_pending_chk: assert property (@(posedge clk) disable iff (rst)
            (ren_fire && ren_dst == AREG_W'(g))
            |=> (!ent_valid[g] && ent_tag[g] == $past(ren_tag)));

        // R5
        wake_chk: assert property (@(posedge clk) disable iff (rst)
            (bc_valid && !ent_valid[g] && ent_tag[g] == bc_tag
             && !(ren_fire && ren_dst == AREG_W'(g)))
            |=> (ent_valid[g] && ent_value[g] == $past(bc_value)));

        // R6
        untouched_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!(ren_fire && ren_dst == AREG_W'(g))
             && !(bc_valid && !ent_valid[g] && ent_tag[g] == bc_tag))
            |=> ($stable(ent_valid[g]) && $stable(ent_value[g]) && $stable(ent_tag[g])));
    end

endmodule

bind rat_rename_table rat_rename_table_chk #(
    .REGS  (REGS),
    .DATA_W(DATA_W),
    .TAGS  (TAGS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rs_avail   (rs_avail),
    .ren_dst    (ren_dst),
    .src_a_idx  (src_a_idx),
    .bc_valid   (bc_valid),
    .bc_tag     (bc_tag),
    .bc_value   (bc_value),
    .ren_fire   (ren_fire),
    .ren_tag    (ren_tag),
    .src_a_ready(src_a_ready),
    .src_a_value(src_a_value),
    .src_a_tag  (src_a_tag),
    .ent_valid  (ent_valid),
    .ent_value  (ent_value),
    .ent_tag    (ent_tag),
    .free_mask  (free_mask)
);

// File: tb/rat_rename_table_tb.sv
module rat_rename_table_tb;

    localparam int REGS   = 8;
    localparam int DATA_W = 16;
    localparam int TAGS   = 8;
    localparam int AREG_W = $clog2(REGS);
    localparam int TAG_W  = $clog2(TAGS);
    localparam int WATCHDOG_CYCLES = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ren_valid = 1'b0;
    logic              rs_avail = 1'b0;
    logic [AREG_W-1:0] ren_dst = '0;
    logic [AREG_W-1:0] src_a_idx = '0;
    logic [AREG_W-1:0] src_b_idx = '0;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_value = '0;
    logic              ren_fire;
    logic [TAG_W-1:0]  ren_tag;
    logic              src_a_ready;
    logic [DATA_W-1:0] src_a_value;
    logic [TAG_W-1:0]  src_a_tag;
    logic              src_b_ready;
    logic [DATA_W-1:0] src_b_value;
    logic [TAG_W-1:0]  src_b_tag;

    always #5 clk = ~clk;

    rat_rename_table #(
        .REGS  (REGS),
        .DATA_W(DATA_W),
        .TAGS  (TAGS)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ren_valid  (ren_valid),
        .rs_avail   (rs_avail),
        .ren_dst    (ren_dst),
        .src_a_idx  (src_a_idx),
        .src_b_idx  (src_b_idx),
        .bc_valid   (bc_valid),
        .bc_tag     (bc_tag),
        .bc_value   (bc_value),
        .ren_fire   (ren_fire),
        .ren_tag    (ren_tag),
        .src_a_ready(src_a_ready),
        .src_a_value(src_a_value),
        .src_a_tag  (src_a_tag),
        .src_b_ready(src_b_ready),
        .src_b_value(src_b_value),
        .src_b_tag  (src_b_tag)
    );

    typedef struct {
        string req;
        bit    fire;
        int    tag;
        bit    a_rdy;
        int    a_val;
        bit    b_rdy;
        int    b_val;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Reference model of the table and tag pool
    bit m_valid [REGS];
    int m_value [REGS];
    int m_tag   [REGS];
    bit m_free  [TAGS];

    function automatic void model_read(input int idx, input bit bcv, input int bct,
                                       input int bcval, output bit rdy, output int val);
        if (m_valid[idx]) begin
            rdy = 1'b1; val = m_value[idx];
        end else if (bcv && bct == m_tag[idx]) begin
            rdy = 1'b1; val = bcval;
        end else begin
            rdy = 1'b0; val = m_tag[idx];
        end
    endfunction

    task automatic drive(input string req, input bit rv, input bit rs, input int dst,
                         input int sa, input int sb, input bit bcv, input int bct,
                         input int bcval);
        exp_t e;
        int   low;
        @(negedge clk);
        ren_valid = rv; rs_avail = rs; ren_dst = AREG_W'(dst);
        src_a_idx = AREG_W'(sa); src_b_idx = AREG_W'(sb);
        bc_valid = bcv; bc_tag = TAG_W'(bct); bc_value = DATA_W'(bcval);
        low = -1;
        for (int t = TAGS - 1; t >= 0; t--) if (m_free[t]) low = t;
        e.req  = req;
        e.fire = rv && rs && (low >= 0);
        e.tag  = e.fire ? low : 0;
        model_read(sa, bcv, bct, bcval, e.a_rdy, e.a_val);
        model_read(sb, bcv, bct, bcval, e.b_rdy, e.b_val);
        exp_q.push_back(e);
        @(posedge clk);
        for (int r = 0; r < REGS; r++) begin
            if (e.fire && dst == r) begin
                m_valid[r] = 1'b0; m_tag[r] = low;
            end else if (bcv && !m_valid[r] && m_tag[r] == bct) begin
                m_valid[r] = 1'b1; m_value[r] = bcval;
            end
        end
        if (e.fire) m_free[low] = 1'b0;
        if (bcv) m_free[bct] = 1'b1;
    endtask

    // Monitor: compare outputs mid-cycle against the queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                int   a_act;
                int   b_act;
                int   t_act;
                e = exp_q.pop_front();
                a_act = src_a_ready ? int'(src_a_value) : int'(src_a_tag);
                b_act = src_b_ready ? int'(src_b_value) : int'(src_b_tag);
                t_act = ren_fire ? int'(ren_tag) : 0;
                n_vec++;
                if (ren_fire !== e.fire || t_act != e.tag || src_a_ready !== e.a_rdy
                    || a_act != e.a_val || src_b_ready !== e.b_rdy || b_act != e.b_val) begin
                    n_bad++;
                    $display("FAIL %s: actual fire=%0d tag=%0d a=%0d/%0h b=%0d/%0h expected fire=%0d tag=%0d a=%0d/%0h b=%0d/%0h",
                             e.req, ren_fire, t_act, src_a_ready, a_act, src_b_ready, b_act,
                             e.fire, e.tag, e.a_rdy, e.a_val, e.b_rdy, e.b_val);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < REGS; r++) begin
            m_valid[r] = 1'b1; m_value[r] = 0; m_tag[r] = 0;
        end
        for (int t = 0; t < TAGS; t++) m_free[t] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register ready with zero after reset
        for (int r = 0; r < REGS; r += 2) drive("R1", 0, 1, 0, r, r + 1, 0, 0, 0);
        // R4 / R8: rename r1 while reading r1; sources see old state, tag 0
        drive("R8", 1, 1, 1, 1, 2, 0, 0, 0);
        // R3: r1 pending on tag 0
        drive("R3", 0, 1, 0, 1, 2, 0, 0, 0);
        // R4: r2 gets tag 1, r1 renamed again gets tag 2
        drive("R4", 1, 1, 2, 1, 2, 0, 0, 0);
        drive("R4", 1, 1, 1, 1, 2, 0, 0, 0);
        // R6: stale broadcast of tag 0 must not wake r1 (now waiting on tag 2)
        drive("R6", 0, 1, 0, 1, 2, 1, 0, 16'h1111);
        drive("R6", 0, 1, 0, 1, 2, 0, 0, 0);
        // R7: bypass of tag 2 on a same-cycle read
        drive("R7", 0, 1, 0, 1, 3, 1, 2, 16'hAAAA);
        // R5 / R2: r1 now valid with captured value
        drive("R5", 0, 1, 0, 1, 3, 0, 0, 0);
        // R9: rename with no scheduling room is refused, r3 untouched
        drive("R9", 1, 0, 3, 3, 1, 0, 0, 0);
        drive("R9", 0, 1, 0, 3, 4, 0, 0, 0);
        // R10: freed tag 0 is the lowest free and is reused
        drive("R10", 1, 1, 4, 4, 3, 0, 0, 0);
        drive("R10", 0, 1, 0, 4, 3, 0, 0, 0);
        // R6: reused tag 0 broadcast must not touch r1, which is valid
        drive("R6", 0, 1, 0, 1, 4, 1, 0, 16'h0BEE);
        drive("R2", 0, 1, 0, 1, 4, 0, 0, 0);
        // R11: rename r2 while its old tag 1 is broadcast; rename wins
        drive("R11", 1, 1, 2, 2, 5, 1, 1, 16'h2222);
        drive("R11", 0, 1, 0, 2, 5, 0, 0, 0);
        // R10: exhaust the pool, then renames stall
        for (int k = 0; k < TAGS + 2; k++) drive("R10", 1, 1, k % REGS, k % REGS, 7, 0, 0, 0);
        // R5 / R10: drain every in-flight tag, then allocate again
        for (int t = 0; t < TAGS; t++) begin
            if (!m_free[t]) drive("R5", 0, 1, 0, t % REGS, (t + 1) % REGS, 1, t, 16'h4000 + t);
        end
        for (int r = 0; r < REGS; r += 2) drive("R2", 0, 1, 0, r, r + 1, 0, 0, 0);
        drive("R10", 1, 1, 6, 6, 0, 0, 0, 0);
        drive("R3", 0, 1, 0, 6, 0, 0, 0, 0);

        drive("R2", 0, 1, 0, 0, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule